// File: doc/BRIEF.md
# CEC Frame Receiver with Logical Address Filter

This block listens to a single open-drain consumer-electronics control line and turns its low pulses into symbols. Each pulse is timed twice: once for how long the line stays low and once for the full period up to the next falling edge. The pair must land inside a programmable window to count as a start bit, a logic 0 or a logic 1. A symbol that lands outside every window inside a frame is a bit error, and so is a low phase that stretches past an abort limit. All times are counted in ticks of a prescaled clock, and every window edge is a parameter. The defaults assume one tick per 10 µs.

After a valid start bit the block gathers ten-bit blocks: eight data bits sent most significant first, an end-of-message bit and an acknowledge bit. Each block goes into a small buffer. The destination nibble of the header block is compared with up to five programmable logical addresses, each with its own enable bit. The broadcast destination 15 is always received. In snoop mode every destination is received, and so are frames sent while the block's own transmitter is active. For a frame that hits an enabled address, the block pulls the line low at the start of every acknowledge bit. When a frame ends, the block raises a ready flag and keeps the frame until software pulses a release strobe. While the ignore control is high, new frames are dropped.

Top module: `cec_frame_rx`

## Requirements
- R1: A frame opens only after a start symbol whose low time is 350 to 390 ticks and whose period, from one falling edge to the next, is 430 to 470 ticks. A start symbol outside these limits opens nothing and reports no error.
- R2: Inside a frame, a logic 0 has a low time of 130 to 170 ticks and a logic 1 has a low time of 40 to 80 ticks. Both need a period of 205 to 275 ticks. The last acknowledge bit of a frame is judged on its low time alone.
- R3: Inside a frame, a symbol that meets no window pulses `bit_err_o` for one cycle and discards the frame. `frame_rdy_o` stays low and `count_o` returns to 0.
- R4: Inside a frame, a low phase longer than 287 ticks flags `bit_err_o` while the line is still low.
- R5: Each stored entry holds the received byte in bits 11:4 and the end-of-message bit in bit 1. Bit 0 is 1 and bits 3:2 are 0. Entry 0 is the header.
- R6: A frame ends at the first block whose end-of-message bit is 1, or after the sixteenth block. `frame_rdy_o` then goes high and `count_o` gives the number of blocks received.
- R7: Slot n (0 to 4) compares its address in `addr_cfg_i[4n+3:4n]` with the header's destination, which is the low nibble of the header byte. The slot takes part only when `addr_cfg_i[24+n]` is 1. A frame is kept when an enabled slot matches or the destination is 15. Any other frame is dropped.
- R8: For a frame kept because an enabled slot matched, `ack_o` is high for 150 ticks. This starts at the falling edge of each block's acknowledge bit. Broadcast frames and frames kept only by snoop mode get no acknowledge.
- R9: While `frame_rdy_o` is high, the buffer and `count_o` stay unchanged and new frames are ignored. A `release_i` pulse clears `frame_rdy_o` and `count_o` on the next cycle.
- R10: A frame whose start symbol ends while `ignore_i` is high is not received.
- R11: A frame whose start symbol ends while `self_tx_i` is high is dropped unless `snoop_i` is high. With `snoop_i` high, a frame to any destination is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Bus line level, asynchronous, passes through a two-flop synchronizer |
| ack_o | output | 1 | 1 pulls the bus line low for an acknowledge |
| addr_cfg_i | input | 32 | Logical address slots: nibble n is slot n, bit 24+n enables slot n |
| snoop_i | input | 1 | Receive every destination and the block's own transmissions |
| ignore_i | input | 1 | Drop frames that start while high |
| self_tx_i | input | 1 | High while the block's own transmitter is sending |
| release_i | input | 1 | One-cycle strobe that frees the buffer |
| rd_idx_i | input | 4 | Buffer entry to show on rd_entry_o |
| rd_entry_o | output | 12 | Stored entry selected by rd_idx_i |
| count_o | output | 5 | Number of blocks in the held frame |
| frame_rdy_o | output | 1 | A complete frame is held |
| bit_err_o | output | 1 | One-cycle pulse on a symbol error inside a frame |

## Verification
The bench sends a one-block frame to each of the sixteen destinations against a mixed slot setup that includes one disabled slot holding a real address. A faulty comparator would then keep a frame it should drop, or miss an acknowledge. The acknowledge length is measured in cycles, so a pulse that is stretched or repeated shows up as a wrong total per block. The bench also covers a frame that ends only because the sixteenth block arrives, which catches a block counter that wraps or a stop test that relies only on the end-of-message bit. Error frames come in three forms: a low phase that is too long, a data low time outside every window, and a period that is too short. A design that did not check the period, or that waited for the rising edge before aborting, would accept the frame or flag the error late.

// File: rtl/cec_frame_rx.sv
module cec_frame_rx #(
  parameter int TICK_DIV    = 100,
  parameter int CW          = 12,
  parameter int DEPTH       = 16,
  parameter int SLOTS       = 5,
  parameter int ST_LO_MIN   = 350,
  parameter int ST_LO_MAX   = 390,
  parameter int ST_PER_MIN  = 430,
  parameter int ST_PER_MAX  = 470,
  parameter int ZR_LO_MIN   = 130,
  parameter int ZR_LO_MAX   = 170,
  parameter int ON_LO_MIN   = 40,
  parameter int ON_LO_MAX   = 80,
  parameter int BIT_PER_MIN = 205,
  parameter int BIT_PER_MAX = 275,
  parameter int LO_ABORT    = 287,
  parameter int ACK_LO      = 150
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_i,
  output logic                         ack_o,
  input  logic [31:0]                  addr_cfg_i,
  input  logic                         snoop_i,
  input  logic                         ignore_i,
  input  logic                         self_tx_i,
  input  logic                         release_i,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx_i,
  output logic [11:0]                  rd_entry_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         frame_rdy_o,
  output logic                         bit_err_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(ACK_LO + 1);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  function automatic logic inwin(input logic [CW-1:0] v, input int lo, input int hi);
    return (v >= CW'(lo)) && (v <= CW'(hi));
  endfunction

  logic s1, s2, ln_q, tick;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; ln_q <= 1'b1;
    end else begin
      s1 <= line_i; s2 <= s1; ln_q <= s2;
    end

  wire fall = ln_q & ~s2;
  wire rise = ~ln_q & s2;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      assign tick = (div_q == DW'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  logic [CW-1:0] lo_cnt, per_cnt, lo_len;
  logic          sym_open, in_frame, matched, last_q, rdy_q, err_q;
  logic [3:0]    bidx;
  logic [IW-1:0] blk;
  logic [NW-1:0] cnt_q;
  logic [7:0]    shreg;
  logic [AW-1:0] ack_cnt;
  logic [11:0]   mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_cnt <= '0; per_cnt <= '0; lo_len <= '0;
    end else begin
      if (fall) per_cnt <= '0;
      else if (tick && per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      if (fall) lo_cnt <= '0;
      else if (tick && !s2 && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (rise) lo_len <= lo_cnt;
    end

  wire lo_zr    = inwin(lo_len, ZR_LO_MIN, ZR_LO_MAX);
  wire lo_on    = inwin(lo_len, ON_LO_MIN, ON_LO_MAX);
  wire per_bit  = inwin(per_cnt, BIT_PER_MIN, BIT_PER_MAX);
  wire is_start = inwin(lo_len, ST_LO_MIN, ST_LO_MAX) && inwin(per_cnt, ST_PER_MIN, ST_PER_MAX);
  wire bit_ok   = (lo_zr | lo_on) & per_bit;
  wire bitv     = lo_on;

  wire [CW-1:0] tmo_lim = in_frame ? CW'(BIT_PER_MAX) : CW'(ST_PER_MAX);
  wire tmo      = sym_open & s2 & (per_cnt > tmo_lim);
  wire long_low = in_frame & ~s2 & ~fall & (lo_cnt > CW'(LO_ABORT));

  wire [3:0] dest = {shreg[2:0], bitv};
  logic [SLOTS-1:0] slot_hit;
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_hit[g] = addr_cfg_i[24+g] && (addr_cfg_i[4*g +: 4] == dest);
    end
  endgenerate
  wire hit  = |slot_hit;
  wire keep = hit | (dest == 4'hF) | snoop_i;

  wire go_ok = sym_open & is_start & ~ignore_i & ~rdy_q & ~release_i & (~self_tx_i | snoop_i);
  wire store = fall & in_frame & sym_open & bit_ok & (bidx == 4'd8);

  always_ff @(posedge clk)
    if (store) mem[blk] <= {shreg, 2'b00, bitv, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sym_open <= 1'b0; in_frame <= 1'b0; matched <= 1'b0; last_q <= 1'b0;
      rdy_q <= 1'b0; err_q <= 1'b0; bidx <= '0; blk <= '0; cnt_q <= '0;
      shreg <= '0; ack_cnt <= '0;
    end else begin
      err_q <= 1'b0;
      if (tick && ack_cnt != '0) ack_cnt <= ack_cnt - 1'b1;
      if (long_low) begin
        in_frame <= 1'b0; err_q <= 1'b1; cnt_q <= '0;
      end else if (fall) begin
        sym_open <= 1'b0;
        if (!in_frame) begin
          if (go_ok) begin
            in_frame <= 1'b1; bidx <= '0; blk <= '0; cnt_q <= '0;
          end
        end else if (!sym_open || !bit_ok) begin
          in_frame <= 1'b0; err_q <= 1'b1; cnt_q <= '0;
        end else begin
          bidx <= bidx + 1'b1;
          if (bidx < 4'd8) shreg <= {shreg[6:0], bitv};
          if (bidx == 4'd7 && blk == '0) begin
            matched <= hit;
            if (!keep) in_frame <= 1'b0;
          end
          if (bidx == 4'd8) begin
            cnt_q  <= NW'(blk) + 1'b1;
            last_q <= bitv || (blk == IW'(DEPTH - 1));
            if (matched) ack_cnt <= AW'(ACK_LO);
          end
          if (bidx == 4'd9) begin
            if (last_q) begin
              in_frame <= 1'b0; rdy_q <= 1'b1;
            end else begin
              bidx <= '0; blk <= blk + 1'b1;
            end
          end
        end
      end else if (tmo) begin
        sym_open <= 1'b0;
        if (in_frame) begin
          in_frame <= 1'b0;
          if (bidx == 4'd9 && last_q && (lo_zr | lo_on)) rdy_q <= 1'b1;
          else begin
            err_q <= 1'b1; cnt_q <= '0;
          end
        end
      end else if (rise) begin
        sym_open <= 1'b1;
      end
      if (release_i) begin
        rdy_q <= 1'b0; cnt_q <= '0;
      end
    end

  assign ack_o       = (ack_cnt != '0);
  assign rd_entry_o  = mem[rd_idx_i];
  assign count_o     = cnt_q;
  assign frame_rdy_o = rdy_q;
  assign bit_err_o   = err_q;
endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk #(
  parameter int TICK_DIV = 100,
  parameter int ACK_LO   = 150,
  parameter int DEPTH    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ack_o,
  input logic                       release_i,
  input logic [$clog2(DEPTH+1)-1:0] count_o,
  input logic                       frame_rdy_o,
  input logic                       bit_err_o
);
  int unsigned ack_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_run <= 0;
    else if (ack_o) ack_run <= ack_run + 1;
    else ack_run <= 0;

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= ($clog2(DEPTH+1))'(DEPTH));

  p_rdy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rdy_o && !release_i |=> frame_rdy_o);

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rdy_o && !release_i |=> $stable(count_o));

  p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> !frame_rdy_o && count_o == '0);

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_o |=> !bit_err_o);

  p_ack_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o && $past(ack_o) |-> (ack_run >= (ACK_LO - 1) * TICK_DIV + 1) && (ack_run <= ACK_LO * TICK_DIV));
endmodule

bind cec_frame_rx cec_frame_rx_chk #(.TICK_DIV(TICK_DIV), .ACK_LO(ACK_LO), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_o(ack_o), .release_i(release_i),
  .count_o(count_o), .frame_rdy_o(frame_rdy_o), .bit_err_o(bit_err_o));

// File: tb/cec_frame_rx_tb.sv
module cec_frame_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_low = 1'b0;
  logic [31:0] addr_cfg = '0;
  logic snoop = 1'b0, ign = 1'b0, self_tx = 1'b0, rel = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [11:0] rd_entry;
  logic [4:0] count;
  logic ack, rdy, berr;
  wire line = ~(tb_low | ack);

  always #2 clk = ~clk;

  cec_frame_rx #(.TICK_DIV(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .ack_o(ack), .addr_cfg_i(addr_cfg),
    .snoop_i(snoop), .ignore_i(ign), .self_tx_i(self_tx), .release_i(rel),
    .rd_idx_i(rd_idx), .rd_entry_o(rd_entry), .count_o(count),
    .frame_rdy_o(rdy), .bit_err_o(berr));

  int checks = 0, errors = 0;
  int ack_cycles = 0, err_seen = 0, err_low = 0;
  logic [7:0] fb [16];
  bit done_flag = 0;

  always @(negedge clk) begin
    if (ack) ack_cycles++;
    if (berr) begin
      err_seen++;
      if (tb_low) err_low++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sym(input int lo, input int per);
    tb_low <= 1'b1;
    repeat (lo) @(posedge clk);
    tb_low <= 1'b0;
    repeat (per - lo) @(posedge clk);
  endtask

  task automatic blockx(input logic [7:0] b, input bit eom);
    for (int i = 7; i >= 0; i--) sym(b[i] ? 60 : 150, 240);
    sym(eom ? 60 : 150, 240);
    sym(60, 240);
  endtask

  task automatic frame(input int slo, input int sper, input int n, input bit eom_last);
    ack_cycles = 0;
    @(posedge clk);
    sym(slo, sper);
    for (int k = 0; k < n; k++) blockx(fb[k], eom_last && (k == n - 1));
    repeat (600) @(posedge clk);
  endtask

  task automatic check_rx(input string req, input bit exp_rdy, input int n, input bit eom_last, input int exp_ack);
    @(negedge clk);
    chk(rdy == exp_rdy, req, "frame ready", rdy, exp_rdy);
    if (exp_rdy) begin
      chk(count == 5'(n), req, "block count", count, n);
      for (int k = 0; k < n; k++) begin
        logic [11:0] e;
        e = {fb[k], 2'b00, (eom_last && k == n - 1), 1'b1};
        rd_idx = 4'(k);
        #1;
        chk(rd_entry == e, "R5", "entry", rd_entry, e);
      end
    end
    chk(ack_cycles == exp_ack, "R8", "ack cycles", ack_cycles, exp_ack);
  endtask

  task automatic release_buf();
    @(posedge clk); rel <= 1'b1;
    @(posedge clk); rel <= 1'b0;
    @(negedge clk);
    chk(!rdy && count == 0, "R9", "after release", {rdy, count}, 0);
  endtask

  function automatic bit slot_match(input logic [31:0] cfg, input logic [3:0] d);
    for (int s = 0; s < 5; s++)
      if (cfg[24+s] && cfg[4*s +: 4] == d) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e0;
    addr_cfg = {3'b000, 5'b11011, 4'h0, 4'hC, 4'h0, 4'h9, 4'h4, 4'h3};
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rdy && count == 0 && !ack && !berr, "R6", "reset state", {rdy, count, ack, berr}, 0);

    // R7 R8: destination sweep over all sixteen values
    for (int d = 0; d < 16; d++) begin
      bit m, kept;
      m = slot_match(addr_cfg, 4'(d));
      kept = m || d == 15;
      fb[0] = {4'hA, 4'(d)};
      frame(370, 450, 1, 1);
      check_rx("R7", kept, 1, 1, m ? 150 : 0);
      if (kept) release_buf();
    end

    // R2 R5 R6: four blocks, end-of-message on the last one
    fb[0] = 8'hA4; fb[1] = 8'h00; fb[2] = 8'hFF; fb[3] = 8'h5A;
    frame(370, 450, 4, 1);
    check_rx("R2", 1, 4, 1, 4 * 150);

    // R9: held frame is not overwritten
    fb[0] = 8'hA3;
    frame(370, 450, 1, 1);
    fb[0] = 8'hA4;
    check_rx("R9", 1, 4, 1, 0);
    release_buf();

    // R6: sixteen blocks without end-of-message
    for (int k = 0; k < 16; k++) fb[k] = 8'(k * 37 + 3);
    fb[0] = 8'h13;
    frame(370, 450, 16, 0);
    check_rx("R6", 1, 16, 0, 16 * 150);
    release_buf();

    // R10: ignore control
    fb[0] = 8'hA3;
    ign = 1'b1;
    frame(370, 450, 1, 1);
    ign = 1'b0;
    check_rx("R10", 0, 1, 1, 0);

    // R11: own transmission, snoop off then on
    self_tx = 1'b1;
    frame(370, 450, 1, 1);
    check_rx("R11", 0, 1, 1, 0);
    snoop = 1'b1;
    fb[0] = 8'hA7;
    frame(370, 450, 1, 1);
    check_rx("R11", 1, 1, 1, 0);
    release_buf();
    self_tx = 1'b0;
    snoop = 1'b0;

    // R1: bad start low time and bad start period
    fb[0] = 8'hA3;
    e0 = err_seen;
    frame(340, 450, 1, 1);
    check_rx("R1", 0, 1, 1, 0);
    frame(370, 490, 1, 1);
    check_rx("R1", 0, 1, 1, 0);
    chk(err_seen == e0, "R1", "no error outside frame", err_seen, e0);

    // R3: data low time outside every window
    e0 = err_seen;
    @(posedge clk);
    sym(370, 450); sym(190, 240);
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk(err_seen == e0 + 1, "R3", "bad low error", err_seen, e0 + 1);
    chk(!rdy && count == 0, "R3", "frame discarded", {rdy, count}, 0);

    // R2 R3: period too short
    e0 = err_seen;
    @(posedge clk);
    sym(370, 450); sym(60, 190); sym(60, 240);
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk(err_seen == e0 + 1, "R2", "short period error", err_seen, e0 + 1);
    chk(!rdy, "R3", "no frame after error", rdy, 0);

    // R4: long low flagged before the line rises
    e0 = err_low;
    @(posedge clk);
    sym(370, 450); sym(400, 450);
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk(err_low == e0 + 1, "R4", "error while low", err_low, e0 + 1);
    chk(!rdy, "R4", "no frame after abort", rdy, 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule